// File: doc/BRIEF.md
# Baud Rate Tick Generator

This block produces the timing strobes for an asynchronous serial port. A free-running prescaler divides the system clock by a power of two, from 1 up to 2048. A 4-bit code held in a small clock-select register picks the ratio. The selected rate comes out as a one-cycle base enable, `base_tick`. A second stage counts these base enables up to a programmable terminal count and emits a one-cycle `baud_tick`. The shift logic of the transmitter and receiver uses `baud_tick` as its bit-clock strobe. No derived clock net exists: every register runs on the system clock and advances on enables.

Software reaches two 8-bit registers through a simple write/read port. The clock-select register sits at address 0 and the divisor register at address 1. The serial port's control logic drives `port_en`. While `port_en` is low, the prescaler and the divider are held cleared, so no strobes appear. The clock-select register can only be rewritten in that state.

A system clock at its upper limit must not use code 0. The base rate has to stay at or below half of the maximum system clock. This rule belongs to the integrator and is not enforced by the hardware.

Top module: `baud_clkgen`

## Requirements
- R1: While `port_en` is 1 and the stored code is k (0 to 11), `base_tick` pulses once every 2^k cycles. The first pulse is in the 2^k-th cycle with `port_en` high. With code 0 it is high in every enabled cycle.
- R2: A read at address 0 returns the stored code in bits 3:0 and zeros in bits 7:4. The code resets to 0, so the read returns 0x00. An accepted write takes its code from `reg_wdata[3:0]`.
- R3: A write to address 0 whose bits 3:2 are both 1 (codes 12 to 15) is rejected and the stored code is unchanged.
- R4: A write to address 0 while `port_en` is 1 is ignored.
- R5: The divisor register at address 1 resets to 0xFF. It accepts every write regardless of `port_en` and reads back the value written.
- R6: `baud_tick` rises only together with `base_tick`. It fires on the N-th base pulse after enable and then on every N-th pulse, where N is the effective divisor.
- R7: The effective divisor N equals the divisor register, except that values 0 to 7 act as 8.
- R8: A divisor written while running takes effect at the next reload. The period in progress ends with the old N.
- R9: While `port_en` is 0, neither strobe is asserted. Raising `port_en` restarts both counters from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable; low holds counters cleared |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 clock-select, 1 divisor |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| base_tick | output | 1 | One-cycle base-rate enable |
| baud_tick | output | 1 | One-cycle baud strobe |

## Verification
Some rules are checked by the assertions on every cycle:
- the stored code never becomes a reserved value, and it never changes while the port is enabled;
- both strobes stay silent when the port is disabled, and `baud_tick` never appears without `base_tick`;
- the upper read bits stay zero;
- at least seven base pulses separate two baud strobes.

The exact cycle of every strobe can only be shown by the bench's scenarios. This covers the phase after enable, the period for each code, the clamping of small divisors and the reload-boundary switch of a divisor changed in mid-run. The scoreboard checks these against times computed from the requirements.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   // register address map of the block
   typedef enum logic {
      SEL_REG = 1'b0,
      DIV_REG = 1'b1
   } bcg_addr_e;
endpackage

// File: rtl/bcg_regs.sv
module bcg_regs
   import bcg_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SEL_W    = 4,
   parameter int DIV_W    = 8,
   parameter int MAX_CODE = 11,
   parameter int DIV_RST  = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [SEL_W-1:0]  sel_q,
   output logic [DIV_W-1:0]  div_q,
   output logic [DATA_W-1:0] reg_rdata
);
   logic [SEL_W-1:0] new_sel;
   logic             sel_ok;
   logic             sel_we;
   logic             div_we;

   assign new_sel = reg_wdata[SEL_W-1:0];
   assign sel_ok  = (new_sel <= SEL_W'(MAX_CODE));
   assign sel_we  = reg_wr && (reg_addr == SEL_REG) && !port_en && sel_ok;
   assign div_we  = reg_wr && (reg_addr == DIV_REG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (sel_we) begin
         sel_q <= new_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= DIV_W'(DIV_RST);
      end else if (div_we) begin
         div_q <= reg_wdata[DIV_W-1:0];
      end
   end

   always_comb begin
      if (reg_addr == SEL_REG) begin
         reg_rdata = DATA_W'(sel_q);
      end else begin
         reg_rdata = DATA_W'(div_q);
      end
   end
endmodule

// File: rtl/bcg_prescaler.sv
module bcg_prescaler #(
   parameter int SEL_W    = 4,
   parameter int MAX_CODE = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             base_tick
);
   localparam int PSC_W = MAX_CODE;

   logic [PSC_W-1:0]  cnt;
   logic [MAX_CODE:0] hit;
   logic              tick_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + PSC_W'(1);
      end
   end

   // stage k fires when the low k prescaler bits are all ones
   assign hit[0] = 1'b1;
   for (genvar k = 1; k <= MAX_CODE; k++) begin : g_stage
      assign hit[k] = &cnt[k-1:0];
   end

   always_comb begin
      tick_sel = 1'b0;
      for (int k = 0; k <= MAX_CODE; k++) begin
         if (sel == SEL_W'(k)) begin
            tick_sel = hit[k];
         end
      end
   end

   assign base_tick = run && tick_sel;
endmodule

// File: rtl/bcg_divider.sv
module bcg_divider #(
   parameter int DIV_W   = 8,
   parameter int MIN_DIV = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             base_tick,
   input  logic [DIV_W-1:0] div,
   output logic             baud_tick
);
   logic [DIV_W-1:0] eff_div;
   logic [DIV_W-1:0] lim_q;
   logic [DIV_W-1:0] dcnt;
   logic             at_end;

   assign eff_div = (div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div;
   assign at_end  = (dcnt == (lim_q - DIV_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt  <= '0;
         lim_q <= DIV_W'(MIN_DIV);
      end else if (!run) begin
         dcnt  <= '0;
         lim_q <= eff_div;
      end else if (base_tick) begin
         if (at_end) begin
            dcnt  <= '0;
            lim_q <= eff_div;
         end else begin
            dcnt  <= dcnt + DIV_W'(1);
         end
      end
   end

   assign baud_tick = run && base_tick && at_end;
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen #(
   parameter int DATA_W   = 8,
   parameter int SEL_W    = 4,
   parameter int DIV_W    = 8,
   parameter int MAX_CODE = 11,
   parameter int MIN_DIV  = 8,
   parameter int DIV_RST  = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              base_tick,
   output logic              baud_tick
);
   if (SEL_W > DATA_W || DIV_W > DATA_W) begin : g_bad_width
      $error("select and divisor fields must fit the data bus");
   end
   if (MAX_CODE < 1 || MAX_CODE >= (1 << SEL_W)) begin : g_bad_code
      $error("MAX_CODE must be encodable in the select field");
   end
   if (MIN_DIV < 1 || MIN_DIV >= (1 << DIV_W)) begin : g_bad_min
      $error("MIN_DIV out of divisor range");
   end
   if (DIV_RST < 0 || DIV_RST >= (1 << DIV_W)) begin : g_bad_rst
      $error("DIV_RST out of divisor range");
   end

   logic [SEL_W-1:0] sel_q;
   logic [DIV_W-1:0] div_q;

   bcg_regs #(
      .DATA_W  (DATA_W),
      .SEL_W   (SEL_W),
      .DIV_W   (DIV_W),
      .MAX_CODE(MAX_CODE),
      .DIV_RST (DIV_RST)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .port_en  (port_en),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .sel_q    (sel_q),
      .div_q    (div_q),
      .reg_rdata(reg_rdata)
   );

   bcg_prescaler #(
      .SEL_W   (SEL_W),
      .MAX_CODE(MAX_CODE)
   ) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (port_en),
      .sel      (sel_q),
      .base_tick(base_tick)
   );

   bcg_divider #(
      .DIV_W  (DIV_W),
      .MIN_DIV(MIN_DIV)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (port_en),
      .base_tick(base_tick),
      .div      (div_q),
      .baud_tick(baud_tick)
   );
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
   parameter int DATA_W   = 8,
   parameter int SEL_W    = 4,
   parameter int DIV_W    = 8,
   parameter int MAX_CODE = 11,
   parameter int MIN_DIV  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              port_en,
   input logic              reg_addr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              base_tick,
   input logic              baud_tick,
   input logic [SEL_W-1:0]  sel_q
);
   // base pulses seen since the last baud strobe
   logic [DIV_W:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap <= '0;
      end else if (!port_en || baud_tick) begin
         gap <= '0;
      end else if (base_tick) begin
         gap <= gap + (DIV_W+1)'(1);
      end
   end

   AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q <= SEL_W'(MAX_CODE)); // R3

   AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      port_en |=> $stable(sel_q)); // R4

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |-> (!base_tick && !baud_tick)); // R9

   AST_BAUD_ON_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> base_tick); // R6

   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 1'b0) |-> (reg_rdata[DATA_W-1:SEL_W] == '0)); // R2

   AST_CODE0_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && sel_q == '0) |-> base_tick); // R1

   AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> (gap >= (DIV_W+1)'(MIN_DIV - 1))); // R7
endmodule

bind baud_clkgen bcg_chk #(
   .DATA_W  (DATA_W),
   .SEL_W   (SEL_W),
   .DIV_W   (DIV_W),
   .MAX_CODE(MAX_CODE),
   .MIN_DIV (MIN_DIV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .port_en  (port_en),
   .reg_addr (reg_addr),
   .reg_rdata(reg_rdata),
   .base_tick(base_tick),
   .baud_tick(baud_tick),
   .sel_q    (sel_q)
);

// File: tb/baud_clkgen_tb.sv
`timescale 1ns/1ps
module baud_clkgen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_en = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       base_tick;
   logic       baud_tick;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int exp_q[$];
   int base_cnt = 0;
   int first_base = -1;
   int idle_ticks = 0;
   bit done = 1'b0;

   baud_clkgen u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .port_en  (port_en),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .base_tick(base_tick),
      .baud_tick(baud_tick)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: samples 1 ns after the falling edge, pops expected strobe times
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && port_en && base_tick) begin
            base_cnt++;
            if (first_base < 0) first_base = cyc;
         end
         if (rst_n && !port_en && (base_tick || baud_tick)) idle_ticks++;
         if (rst_n && baud_tick) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 unexpected baud_tick", cyc, -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               check(cyc == e, "R6 baud_tick cycle", cyc, e);
            end
         end
      end
   end

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(input logic a, input int exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
   endtask

   // enable, push expected strobe times, run, disable and check counts
   task automatic run_case(input int k, input int n, input int nt, input string req);
      int c;
      int last;
      int e;
      int per;
      per = n << k;
      @(negedge clk);
      c = cyc;
      base_cnt = 0;
      first_base = -1;
      port_en = 1'b1;
      for (int m = 0; m < nt; m++) exp_q.push_back(c + per - 1 + m * per);
      last = c + nt * per - 1;
      while (cyc < last + 2) @(negedge clk);
      e = cyc;
      port_en = 1'b0;
      #2;
      check(exp_q.size() == 0, {req, " missing baud ticks"}, exp_q.size(), 0);
      exp_q.delete();
      check(first_base == c + (1 << k) - 1, {req, " R1 first base_tick"}, first_base, c + (1 << k) - 1);
      check(base_cnt == ((e - c) >> k), {req, " R1 base_tick count"}, base_cnt, (e - c) >> k);
   endtask

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      rd_check(1'b0, 8'h00, "R2 reset select");
      rd_check(1'b1, 8'hFF, "R5 reset divisor");
      // select write, upper bits dropped
      wr(1'b0, 8'hF5);
      rd_check(1'b0, 8'h05, "R2 select readback");
      // reserved codes rejected
      wr(1'b0, 8'h0C);
      rd_check(1'b0, 8'h05, "R3 code 12 rejected");
      wr(1'b0, 8'h0F);
      rd_check(1'b0, 8'h05, "R3 code 15 rejected");
      // write while enabled ignored
      @(negedge clk); port_en = 1'b1;
      wr(1'b0, 8'h02);
      @(negedge clk); port_en = 1'b0;
      rd_check(1'b0, 8'h05, "R4 locked while enabled");
      wr(1'b1, 8'd10);
      rd_check(1'b1, 10, "R5 divisor readback");
      run_case(5, 10, 3, "R4 code 5 kept");
      // idle quiet
      repeat (50) @(negedge clk);
      check(idle_ticks == 0, "R9 no strobes while disabled", idle_ticks, 0);
      // code 0, divisor 8
      wr(1'b0, 8'h00);
      wr(1'b1, 8'd8);
      run_case(0, 8, 4, "R6 code 0 div 8");
      // divisor 255
      wr(1'b1, 8'd255);
      run_case(0, 255, 2, "R5 div 255");
      // small divisors clamp to 8
      wr(1'b0, 8'h03);
      wr(1'b1, 8'd3);
      rd_check(1'b1, 3, "R5 divisor 3 readback");
      run_case(3, 8, 3, "R7 div 3 acts as 8");
      wr(1'b0, 8'h00);
      wr(1'b1, 8'd0);
      run_case(0, 8, 2, "R7 div 0 acts as 8");
      // largest code
      wr(1'b0, 8'h0B);
      wr(1'b1, 8'd8);
      rd_check(1'b0, 8'h0B, "R2 code 11 readback");
      run_case(11, 8, 2, "R1 code 11");
      // divisor change while running
      wr(1'b0, 8'h01);
      wr(1'b1, 8'd10);
      @(negedge clk);
      c = cyc;
      base_cnt = 0;
      port_en = 1'b1;
      exp_q.push_back(c + 19);
      exp_q.push_back(c + 39);
      exp_q.push_back(c + 79);
      exp_q.push_back(c + 119);
      while (cyc < c + 25) @(negedge clk);
      reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'd20;
      @(negedge clk);
      reg_wr = 1'b0;
      while (cyc < c + 121) @(negedge clk);
      port_en = 1'b0;
      #2;
      check(exp_q.size() == 0, "R8 reload boundary switch", exp_q.size(), 0);
      exp_q.delete();
      repeat (20) @(negedge clk);
      check(idle_ticks == 0, "R9 quiet after runs", idle_ticks, 0);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // watchdog
   initial begin
      while (cyc < 150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule